// File: doc/BRIEF.md
# Snoop-Hit Write-Back Line Buffer

This block sits beside a shared bus and catches the cache line that a snooping processor pushes out when another agent's read hits a line it holds in the Modified state. The snooping processor answers such a read with an address-retry, and then writes the dirty line back as a burst. The buffer stores that burst together with its line address. When the retried read comes back, the buffer returns the line itself, so the bus does not need a second memory access to the same address.

The captured line is still written to memory through a dedicated write port, one word per accepted beat. Memory costs six cycles for the first word and one per later word, while a buffer hit returns its first word in the cycle after the request. The buffer holds exactly one line. A later snoop hit has to wait, under a stall signal, until the held line has been fully written to memory. A bus write to the held line updates the stored copy, so later hits never return stale words. Reads to any other line are handed to memory with a one-cycle forward pulse.

Top module: `snoop_wb_buffer`

## Requirements
- R1: After synchronous reset, `snoop_stall`, `rd_valid`, `rd_fwd` and `mw_valid` are all low.
- R2: A write-back burst of eight beats, whose first beat carries `wb_first` high and the line address, is stored as words at offsets 0 to 7 in beat order. `snoop_stall` is high from the cycle after the first beat until the buffer is released.
- R3: Once all eight words are captured, the line is written to memory with `mw_valid`. The word address is {line, offset}, and the offsets run 0 to 7 with one word per cycle in which `mw_ready` is high. Address and valid hold steady while `mw_ready` is low.
- R4: A read request whose line equals the held line returns eight words in offset order on consecutive cycles. The first word arrives in the cycle after the request, and `rd_last` is high with the eighth word.
- R5: A read request that does not hit causes `rd_fwd` to pulse for one cycle, in the cycle after the request, with `rd_fwd_line` equal to the requested line. It produces no `rd_valid`. A miss is a request to another line or a request while the buffer is empty.
- R6: A bus write to a word of the held line replaces that word in the buffer, and later hits and the memory write return the new value. A bus write to any other line leaves the buffer unchanged.
- R7: The buffer is released only after its memory write is complete and no hit burst is in progress. The release comes one cycle after both are true, and `snoop_stall` then falls. From then on, reads of that line are forwarded.
- R8: While the buffer holds an undrained line, `snoop_stall` stays high. After release, a new write-back burst is captured and served with its own data.
- R9: A read request that arrives while a hit burst is being returned is forwarded to memory under R5. The burst in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_valid | input | 1 | Write-back beat valid |
| wb_first | input | 1 | Marks the first beat of a write-back burst |
| wb_line | input | 27 | Line address, sampled on the first beat |
| wb_data | input | 32 | Write-back word |
| snoop_stall | output | 1 | Buffer occupied; a new snoop hit must wait |
| bw_valid | input | 1 | Bus write to a single word |
| bw_addr | input | 30 | Word address of the bus write |
| bw_data | input | 32 | Bus write data |
| rd_req | input | 1 | Read request (retried read) |
| rd_line | input | 27 | Line address of the read |
| rd_valid | output | 1 | Buffered read word valid |
| rd_data | output | 32 | Buffered read word |
| rd_last | output | 1 | Last word of a buffered read |
| rd_fwd | output | 1 | Read forwarded to memory |
| rd_fwd_line | output | 27 | Line address of the forwarded read |
| mw_valid | output | 1 | Memory write word valid |
| mw_addr | output | 30 | Memory write word address |
| mw_data | output | 32 | Memory write word |
| mw_ready | input | 1 | Memory accepts the current word |

## Verification
Hit reads are issued against a held line both before and after a bus write to one of its words. This separates a buffer that really stores the line from one that only replays the capture, and shows that a write to another line changes nothing. Misses are tried against a foreign line, a line already released, and a request in the middle of a burst, so that a forward can be told apart from a hit. The memory write is driven once with `mw_ready` toggling and once with it held high while a hit burst runs, which exposes ordering faults and any release that comes too early.

// File: rtl/snb_pkg.sv
package snb_pkg;
    localparam int WORD_W     = 32;
    localparam int LINE_WORDS = 8;
    localparam int WADDR_W    = 30;
    localparam int OFF_W      = $clog2(LINE_WORDS);
    localparam int LINE_AW    = WADDR_W - OFF_W;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [OFF_W-1:0]   off_t;
    typedef logic [LINE_AW-1:0] line_t;
    typedef logic [WADDR_W-1:0] waddr_t;

    typedef enum logic [1:0] {
        BUF_EMPTY,
        BUF_FILL,
        BUF_HELD
    } buf_state_e;

    localparam off_t LAST_OFF = off_t'(LINE_WORDS - 1);

    function automatic waddr_t join_addr(line_t l, off_t o);
        return {l, o};
    endfunction

    function automatic line_t line_of(waddr_t a);
        return a[WADDR_W-1:OFF_W];
    endfunction

    function automatic off_t off_of(waddr_t a);
        return a[OFF_W-1:0];
    endfunction
endpackage

// File: rtl/snb_line_store.sv
module snb_line_store
    import snb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wb_valid,
    input  logic   wb_first,
    input  line_t  wb_line,
    input  word_t  wb_data,
    input  logic   bw_valid,
    input  waddr_t bw_addr,
    input  word_t  bw_data,
    input  logic   release_i,
    input  off_t   off_a,
    input  off_t   off_b,
    output logic   held,
    output logic   busy,
    output line_t  line_q,
    output word_t  word_a,
    output word_t  word_b
);
    buf_state_e state;
    off_t       fill_cnt;
    word_t      mem [LINE_WORDS];

    logic  wr_en;
    off_t  wr_idx;
    word_t wr_data;
    logic  bw_hit;

    assign bw_hit = bw_valid && (state == BUF_HELD) && (line_of(bw_addr) == line_q);

    always_comb begin
        wr_en   = 1'b0;
        wr_idx  = '0;
        wr_data = wb_data;
        unique case (state)
            BUF_EMPTY: if (wb_valid && wb_first) begin
                wr_en  = 1'b1;
                wr_idx = '0;
            end
            BUF_FILL: if (wb_valid) begin
                wr_en  = 1'b1;
                wr_idx = fill_cnt;
            end
            BUF_HELD: if (bw_hit) begin
                wr_en   = 1'b1;
                wr_idx  = off_of(bw_addr);
                wr_data = bw_data;
            end
            default: wr_en = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= BUF_EMPTY;
            fill_cnt <= '0;
            line_q   <= '0;
        end else begin
            unique case (state)
                BUF_EMPTY: if (wb_valid && wb_first) begin
                    line_q   <= wb_line;
                    fill_cnt <= off_t'(1);
                    state    <= BUF_FILL;
                end
                BUF_FILL: if (wb_valid) begin
                    fill_cnt <= fill_cnt + off_t'(1);
                    if (fill_cnt == LAST_OFF) state <= BUF_HELD;
                end
                BUF_HELD: if (release_i) state <= BUF_EMPTY;
                default: state <= BUF_EMPTY;
            endcase
        end
    end

    assign held   = (state == BUF_HELD);
    assign busy   = (state != BUF_EMPTY);
    assign word_a = mem[off_a];
    assign word_b = mem[off_b];

    // R8: a new burst may only start into an empty buffer
    assert_fill_only_when_free_R8: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && wb_first) |-> (state == BUF_EMPTY));

    // R7: a held line stays held until released
    assert_hold_until_release_R7: assert property (@(posedge clk) disable iff (rst)
        (held && !release_i) |=> held);

    // R2: once the line is held, the stall is up
    assert_stall_while_held_R2: assert property (@(posedge clk) disable iff (rst)
        held |-> busy);
endmodule

// File: rtl/snb_drain_seq.sv
module snb_drain_seq
    import snb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   held,
    input  line_t  line_q,
    input  word_t  word,
    input  logic   mw_ready,
    output logic   mw_valid,
    output waddr_t mw_addr,
    output word_t  mw_data,
    output off_t   ptr,
    output logic   done
);
    always_ff @(posedge clk) begin
        if (rst || !held) begin
            ptr  <= '0;
            done <= 1'b0;
        end else if (mw_valid && mw_ready) begin
            if (ptr == LAST_OFF) begin
                done <= 1'b1;
                ptr  <= '0;
            end else begin
                ptr <= ptr + off_t'(1);
            end
        end
    end

    assign mw_valid = held && !done;
    assign mw_addr  = join_addr(line_q, ptr);
    assign mw_data  = word;

    // R3: a stalled beat keeps its address and stays valid
    assert_hold_under_backpressure_R3: assert property (@(posedge clk) disable iff (rst)
        (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr)));

    // R3: accepted beats advance the offset by one
    assert_offsets_in_order_R3: assert property (@(posedge clk) disable iff (rst)
        (mw_valid && mw_ready && (off_of(mw_addr) != LAST_OFF)) |=>
        (mw_valid && (off_of(mw_addr) == off_of($past(mw_addr)) + off_t'(1))));
endmodule

// File: rtl/snb_read_seq.sv
module snb_read_seq
    import snb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_req,
    input  line_t rd_line,
    input  logic  held,
    input  line_t buf_line,
    input  word_t word,
    output logic  rd_valid,
    output word_t rd_data,
    output logic  rd_last,
    output logic  rd_fwd,
    output line_t rd_fwd_line,
    output off_t  ptr,
    output logic  active
);
    logic hit;

    assign hit = rd_req && held && (rd_line == buf_line) && !active;

    always_ff @(posedge clk) begin
        if (rst) begin
            active      <= 1'b0;
            ptr         <= '0;
            rd_fwd      <= 1'b0;
            rd_fwd_line <= '0;
        end else begin
            rd_fwd <= rd_req && !hit;
            if (rd_req) rd_fwd_line <= rd_line;
            if (hit) begin
                active <= 1'b1;
                ptr    <= '0;
            end else if (active) begin
                if (ptr == LAST_OFF) active <= 1'b0;
                else                 ptr    <= ptr + off_t'(1);
            end
        end
    end

    assign rd_valid = active;
    assign rd_data  = word;
    assign rd_last  = active && (ptr == LAST_OFF);

    // R4: a burst starts only in answer to a request
    assert_burst_needs_request_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid) |-> $past(rd_req));

    // R4: the last word closes the burst
    assert_last_ends_burst_R4: assert property (@(posedge clk) disable iff (rst)
        rd_last |=> !rd_valid);

    // R7: buffered words are only returned from a held line
    assert_burst_from_held_R7: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> held);
endmodule

// File: rtl/snoop_wb_buffer.sv
module snoop_wb_buffer
    import snb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wb_valid,
    input  logic               wb_first,
    input  logic [LINE_AW-1:0] wb_line,
    input  logic [WORD_W-1:0]  wb_data,
    output logic               snoop_stall,
    input  logic               bw_valid,
    input  logic [WADDR_W-1:0] bw_addr,
    input  logic [WORD_W-1:0]  bw_data,
    input  logic               rd_req,
    input  logic [LINE_AW-1:0] rd_line,
    output logic               rd_valid,
    output logic [WORD_W-1:0]  rd_data,
    output logic               rd_last,
    output logic               rd_fwd,
    output logic [LINE_AW-1:0] rd_fwd_line,
    output logic               mw_valid,
    output logic [WADDR_W-1:0] mw_addr,
    output logic [WORD_W-1:0]  mw_data,
    input  logic               mw_ready
);
    logic  held, busy, drain_done, rd_active, release_buf;
    line_t line_q;
    off_t  drain_ptr, rd_ptr;
    word_t drain_word, rd_word;

    assign release_buf = drain_done && !rd_active && !rd_req;
    assign snoop_stall = busy;

    snb_line_store u_store (
        .clk       (clk),
        .rst       (rst),
        .wb_valid  (wb_valid),
        .wb_first  (wb_first),
        .wb_line   (wb_line),
        .wb_data   (wb_data),
        .bw_valid  (bw_valid),
        .bw_addr   (bw_addr),
        .bw_data   (bw_data),
        .release_i (release_buf),
        .off_a     (drain_ptr),
        .off_b     (rd_ptr),
        .held      (held),
        .busy      (busy),
        .line_q    (line_q),
        .word_a    (drain_word),
        .word_b    (rd_word)
    );

    snb_drain_seq u_drain (
        .clk      (clk),
        .rst      (rst),
        .held     (held),
        .line_q   (line_q),
        .word     (drain_word),
        .mw_ready (mw_ready),
        .mw_valid (mw_valid),
        .mw_addr  (mw_addr),
        .mw_data  (mw_data),
        .ptr      (drain_ptr),
        .done     (drain_done)
    );

    snb_read_seq u_read (
        .clk         (clk),
        .rst         (rst),
        .rd_req      (rd_req),
        .rd_line     (rd_line),
        .held        (held),
        .buf_line    (line_q),
        .word        (rd_word),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .rd_last     (rd_last),
        .rd_fwd      (rd_fwd),
        .rd_fwd_line (rd_fwd_line),
        .ptr         (rd_ptr),
        .active      (rd_active)
    );

    // R7: the stall only drops after the memory write completed
    assert_release_after_drain_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(held) |-> $past(drain_done));

    // R9: a request during a burst never interrupts it
    assert_burst_not_cut_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_last) |=> rd_valid);
endmodule

// File: tb/snoop_wb_buffer_test.sv
`timescale 1ns/1ps
module snoop_wb_buffer_test;
    import snb_pkg::*;

    logic   clk = 1'b0;
    logic   rst = 1'b1;
    logic   wb_valid = 1'b0, wb_first = 1'b0;
    line_t  wb_line = '0;
    word_t  wb_data = '0;
    logic   snoop_stall;
    logic   bw_valid = 1'b0;
    waddr_t bw_addr = '0;
    word_t  bw_data = '0;
    logic   rd_req = 1'b0;
    line_t  rd_line = '0;
    logic   rd_valid, rd_last, rd_fwd;
    word_t  rd_data;
    line_t  rd_fwd_line;
    logic   mw_valid;
    waddr_t mw_addr;
    word_t  mw_data;
    logic   mw_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    word_t  exp_line [LINE_WORDS];
    word_t  mem_data [LINE_WORDS];
    waddr_t mem_addr [LINE_WORDS];
    int     mem_cnt = 0;

    localparam line_t LINE_A = line_t'(27'h0000123);
    localparam line_t LINE_B = line_t'(27'h0000456);

    always #2.5 clk = ~clk;

    snoop_wb_buffer uut (
        .clk(clk), .rst(rst),
        .wb_valid(wb_valid), .wb_first(wb_first), .wb_line(wb_line), .wb_data(wb_data),
        .snoop_stall(snoop_stall),
        .bw_valid(bw_valid), .bw_addr(bw_addr), .bw_data(bw_data),
        .rd_req(rd_req), .rd_line(rd_line),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
        .rd_fwd(rd_fwd), .rd_fwd_line(rd_fwd_line),
        .mw_valid(mw_valid), .mw_addr(mw_addr), .mw_data(mw_data), .mw_ready(mw_ready)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mw_valid && mw_ready && mem_cnt < LINE_WORDS) begin
            mem_data[mem_cnt] <= mw_data;
            mem_addr[mem_cnt] <= mw_addr;
            mem_cnt <= mem_cnt + 1;
        end
    end

    always @(posedge clk) begin
        if (cyc == 20000 && !finished) begin
            finished = 1'b1;
            errors = errors + 1;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 stall", 64'(snoop_stall), 0);
        chk("R1 rd_valid", 64'(rd_valid), 0);
        chk("R1 rd_fwd", 64'(rd_fwd), 0);
        chk("R1 mw_valid", 64'(mw_valid), 0);
    endtask

    task automatic t_capture(input line_t ln, input word_t base);
        for (int i = 0; i < LINE_WORDS; i++) begin
            @(negedge clk);
            if (i == 1) chk("R2 stall during fill", 64'(snoop_stall), 1);
            wb_valid = 1'b1;
            wb_first = (i == 0);
            wb_line  = ln;
            wb_data  = base + word_t'(i);
            exp_line[i] = base + word_t'(i);
        end
        @(negedge clk);
        wb_valid = 1'b0;
        wb_first = 1'b0;
        chk("R2 stall when held", 64'(snoop_stall), 1);
        chk("R3 drain valid", 64'(mw_valid), 1);
        chk("R3 first address", 64'(mw_addr), 64'(join_addr(ln, '0)));
    endtask

    task automatic t_hit_read(input line_t ln, input string req);
        @(negedge clk);
        rd_req = 1'b1;
        rd_line = ln;
        @(negedge clk);
        rd_req = 1'b0;
        for (int i = 0; i < LINE_WORDS; i++) begin
            chk({req, " rd_valid"}, 64'(rd_valid), 1);
            chk({req, " rd_data"}, 64'(rd_data), 64'(exp_line[i]));
            chk({req, " rd_last"}, 64'(rd_last), 64'(i == LINE_WORDS - 1));
            @(negedge clk);
        end
        chk({req, " burst end"}, 64'(rd_valid), 0);
    endtask

    task automatic t_miss(input line_t ln, input string req);
        @(negedge clk);
        rd_req = 1'b1;
        rd_line = ln;
        @(negedge clk);
        rd_req = 1'b0;
        chk({req, " rd_fwd"}, 64'(rd_fwd), 1);
        chk({req, " rd_fwd_line"}, 64'(rd_fwd_line), 64'(ln));
        chk({req, " no data"}, 64'(rd_valid), 0);
        @(negedge clk);
        chk({req, " fwd pulse"}, 64'(rd_fwd), 0);
    endtask

    task automatic t_bus_write(input waddr_t a, input word_t d, input line_t held_line);
        @(negedge clk);
        bw_valid = 1'b1;
        bw_addr = a;
        bw_data = d;
        if (line_of(a) == held_line) exp_line[off_of(a)] = d;
        @(negedge clk);
        bw_valid = 1'b0;
    endtask

    // R9: request in the middle of a burst
    task automatic t_req_during_burst(input line_t ln);
        @(negedge clk);
        rd_req = 1'b1;
        rd_line = ln;
        @(negedge clk);
        chk("R9 first is hit", 64'(rd_fwd), 0);
        chk("R9 word0", 64'(rd_data), 64'(exp_line[0]));
        @(negedge clk);
        rd_req = 1'b0;
        chk("R9 forwarded", 64'(rd_fwd), 1);
        chk("R9 burst continues", 64'(rd_valid), 1);
        chk("R9 word1", 64'(rd_data), 64'(exp_line[1]));
        while (rd_valid) @(negedge clk);
    endtask

    task automatic t_drain_toggle(input line_t ln);
        mem_cnt = 0;
        for (int k = 0; k < 60 && mem_cnt < LINE_WORDS; k++) begin
            @(negedge clk);
            if (mem_cnt < LINE_WORDS) chk("R8 stall before drain done", 64'(snoop_stall), 1);
            mw_ready = ~mw_ready;
        end
        mw_ready = 1'b0;
        for (int i = 0; i < LINE_WORDS; i++) begin
            chk("R3 memory address", 64'(mem_addr[i]), 64'(join_addr(ln, off_t'(i))));
            chk("R3 R6 memory data", 64'(mem_data[i]), 64'(exp_line[i]));
        end
        @(negedge clk);
        @(negedge clk);
        chk("R7 stall released", 64'(snoop_stall), 0);
        chk("R7 no drain after release", 64'(mw_valid), 0);
    endtask

    // R7: hit burst overlapping the drain holds the release
    task automatic t_read_with_drain(input line_t ln);
        mem_cnt = 0;
        @(negedge clk);
        rd_req = 1'b1;
        rd_line = ln;
        mw_ready = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        for (int i = 0; i < LINE_WORDS; i++) begin
            chk("R4 R8 new line data", 64'(rd_data), 64'(exp_line[i]));
            chk("R4 valid", 64'(rd_valid), 1);
            if (i == LINE_WORDS - 1) chk("R7 stall held at last word", 64'(snoop_stall), 1);
            @(negedge clk);
        end
        mw_ready = 1'b0;
        chk("R7 stall held one more cycle", 64'(snoop_stall), 1);
        @(negedge clk);
        chk("R7 stall drops", 64'(snoop_stall), 0);
        for (int i = 0; i < LINE_WORDS; i++) begin
            chk("R3 second line memory data", 64'(mem_data[i]), 64'(exp_line[i]));
            chk("R3 second line address", 64'(mem_addr[i]), 64'(join_addr(ln, off_t'(i))));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_miss(LINE_A, "R5 empty buffer");
        t_capture(LINE_A, 32'hA000_0000);
        repeat (4) @(negedge clk);
        chk("R8 stall while undrained", 64'(snoop_stall), 1);
        t_hit_read(LINE_A, "R4 hit");
        t_bus_write(join_addr(LINE_A, off_t'(3)), 32'hDEAD_BEEF, LINE_A);
        t_bus_write(join_addr(LINE_B, off_t'(5)), 32'h0BAD_F00D, LINE_A);
        t_hit_read(LINE_A, "R6 updated");
        t_miss(LINE_B, "R5 other line");
        t_req_during_burst(LINE_A);
        t_drain_toggle(LINE_A);
        t_miss(LINE_A, "R7 after release");
        t_capture(LINE_B, 32'hB000_0000);
        t_read_with_drain(LINE_B);
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule